// File: doc/BRIEF.md
# Transmit Byte Queue with Packet Markers

This block is a 32-word holding queue that sits between a host bus writing one word per cycle and a bit-serial transmit framer that takes words through a valid/ready handshake. Each word holds an 8-bit payload byte together with two marker bits that flag the first and last byte of a packet. When the framer is set to pass bytes through without packet handling, the markers are hidden from it, but they are still stored.

For polled use the host can read the current occupancy and a set of status flags at any time. For interrupt-driven use, five level conditions are reported: queue empty, queue holding data, queue full, queue with room, and occupancy at or below a programmable threshold. Each condition has its own enable, and a single request line is the OR of the enabled conditions. No condition can be cleared by writing a bit. It drops only when the host or the framer changes the occupancy. A DMA request line asks a transfer engine to top up the queue while the occupancy is below the threshold.

A write to a full queue is discarded and sets a sticky overflow flag. The flag stays set until the host clears it.

Top module: `txq_meta_fifo`

## Requirements
- R1: While reset is asserted, and after it is released, the queue is empty: `fill_count` is 0, `st_empty` is 1, `st_full` is 0, `st_overflow` is 0 and `rd_valid` is 0.
- R2: Words leave in the order they were accepted. `rd_data` shows bits [7:0] of the oldest stored word while `rd_valid` is high, and it stays stable while the framer stalls.
- R3: A write while `fill_count` is 32 is discarded, even if a read happens in the same cycle. It sets `st_overflow`, which then stays at 1 until a cycle with `ovf_clr` high and no discarded write. When both occur in the same cycle, setting wins.
- R4: `rd_valid` is high exactly when `fill_count` is nonzero. A word is removed only in a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` on an empty queue changes nothing.
- R5: `fill_count` goes up by one for an accepted write without a read, down by one for a read without a write, and stays the same when both happen. A write to an empty queue together with `rd_ready` only adds the word.
- R6: `fill_count` ranges from 0 to 32. `st_full` is 1 exactly at 32 and `st_empty` is 1 exactly at 0.
- R7: `rd_meta` shows bits [9:8] of the oldest word when `raw_mode` is 0 and is 00 when `raw_mode` is 1. The stored markers survive a period in raw mode.
- R8: `irq_pend` gives the conditions as levels: bit 0 empty, bit 1 not empty, bit 2 full, bit 3 not full, bit 4 `fill_count` <= `lvl_thr`. Each condition clears only through a change of occupancy or threshold.
- R9: `irq` is high exactly when some bit of `irq_pend` is high and the bit of `irq_en` at the same position is also high.
- R10: `dma_req` is high exactly when `dma_en` is 1 and `fill_count` < `lvl_thr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the host bus |
| wr_word | input | 10 | Marker bits [9:8] and payload byte [7:0] |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| raw_mode | input | 1 | Hides the marker bits from the framer |
| irq_en | input | 5 | Per-condition interrupt enables, positions as in `irq_pend` |
| lvl_thr | input | 5 | Fill threshold for the level condition and DMA request |
| dma_en | input | 1 | Enables the DMA request |
| rd_valid | output | 1 | Oldest word is presented to the framer |
| rd_ready | input | 1 | Framer takes the presented word |
| rd_data | output | 8 | Payload byte of the oldest word |
| rd_meta | output | 2 | Marker bits of the oldest word, 00 in raw mode |
| fill_count | output | 6 | Number of stored words, 0 to 32 |
| st_empty | output | 1 | Queue holds no word |
| st_full | output | 1 | Queue holds 32 words |
| st_overflow | output | 1 | Sticky flag for a discarded write |
| irq_pend | output | 5 | Raw interrupt conditions |
| irq | output | 1 | OR of enabled conditions |
| dma_req | output | 1 | Request to refill the queue |

## Verification
The bench targets a write to a full queue that coincides with a read. A design that judges fullness after the read would accept that word and report 32 entries where 31 are expected. It also targets the clear and set of the overflow flag in the same cycle; a design that lets the clear win would lose the record of a dropped byte. A read strobe on an empty queue, together with a write, must not advance the read pointer, or the framer would receive a stale word. The bench also toggles raw mode while packets are queued, to catch a design that wipes the stored markers instead of masking them at the output, and it sweeps the threshold across the occupancy to catch an off-by-one between the inclusive level condition and the strict DMA comparison.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // positions of the interrupt conditions in the pending vector
  localparam int unsigned SRC_EMPTY    = 0;
  localparam int unsigned SRC_NEMPTY   = 1;
  localparam int unsigned SRC_FULL     = 2;
  localparam int unsigned SRC_NFULL    = 3;
  localparam int unsigned SRC_LEVEL    = 4;
  localparam int unsigned IRQ_SRC_N    = 5;

  typedef logic [IRQ_SRC_N-1:0] irq_vec_t;
endpackage

// File: rtl/txq_store.sv
// Word storage with read and write pointers; head word is shown ahead of the pop.
module txq_store #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WORD_W = 10,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [AW-1:0]     wr_ptr_inc, rd_ptr_inc;

  // pointer advance: free wrap for a power-of-two depth, compare otherwise
  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_ptr_inc = wr_ptr_q + 1'b1;
      assign rd_ptr_inc = rd_ptr_q + 1'b1;
    end else begin : g_mod
      assign wr_ptr_inc = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_inc = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = wr_ptr_inc;
    if (pop)  rd_ptr_d = rd_ptr_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_d;
      if (pop)  rd_ptr_q <= rd_ptr_d;
    end
  end

  // storage array carries no reset; only the pointers define validity
  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= push_word;
  end

  assign head_word = mem_q[rd_ptr_q];

endmodule

// File: rtl/txq_count.sv
// Occupancy counter, push/pop qualification and the sticky overflow flag.
module txq_count #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_ready,
  input  logic          ovf_clr,
  output logic          push,
  output logic          pop,
  output logic [CW-1:0] count,
  output logic          is_empty,
  output logic          is_full,
  output logic          overflow
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          empty_q, empty_d;
  logic          full_q, full_d;
  logic          ovf_q, ovf_d;
  logic          cnt_en;

  // fullness is judged on the count before this cycle's read
  assign push   = wr_en && !full_q;
  assign pop    = rd_ready && !empty_q;
  assign cnt_en = push ^ pop;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
    empty_d = (cnt_d == '0);
    full_d  = (cnt_d == FULL_CNT);
  end

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_clr)             ovf_d = 1'b0;
    if (wr_en && full_q)     ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign count    = cnt_q;
  assign is_empty = empty_q;
  assign is_full  = full_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/txq_irq.sv
// Level interrupt conditions, enable masking and the refill request.
module txq_irq
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  logic [CW-1:0] count,
  input  logic          is_empty,
  input  logic          is_full,
  input  logic [TW-1:0] lvl_thr,
  input  irq_vec_t      irq_en,
  input  logic          dma_en,
  output irq_vec_t      pend,
  output logic          irq,
  output logic          dma_req
);

  logic [CW-1:0] thr_ext;
  irq_vec_t      masked;

  assign thr_ext = CW'(lvl_thr);

  always_comb begin
    pend             = '0;
    pend[SRC_EMPTY]  = is_empty;
    pend[SRC_NEMPTY] = !is_empty;
    pend[SRC_FULL]   = is_full;
    pend[SRC_NFULL]  = !is_full;
    pend[SRC_LEVEL]  = (count <= thr_ext);
  end

  generate
    for (genvar i = 0; i < IRQ_SRC_N; i++) begin : g_mask
      assign masked[i] = pend[i] & irq_en[i];
    end
  endgenerate

  assign irq     = |masked;
  assign dma_req = dma_en && (count < thr_ext);

endmodule

// File: rtl/txq_meta_fifo.sv
// Transmit queue top: storage, occupancy and interrupt logic.
module txq_meta_fifo
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned META_W = 2,
  localparam int unsigned WORD_W = DATA_W + META_W,
  localparam int unsigned CW     = $clog2(DEPTH + 1),
  localparam int unsigned TW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              ovf_clr,
  input  logic              raw_mode,
  input  logic [IRQ_SRC_N-1:0] irq_en,
  input  logic [TW-1:0]     lvl_thr,
  input  logic              dma_en,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [META_W-1:0] rd_meta,
  output logic [CW-1:0]     fill_count,
  output logic              st_empty,
  output logic              st_full,
  output logic              st_overflow,
  output logic [IRQ_SRC_N-1:0] irq_pend,
  output logic              irq,
  output logic              dma_req
);

  logic              push, pop;
  logic [CW-1:0]     count;
  logic              is_empty, is_full;
  logic [WORD_W-1:0] head_word;
  irq_vec_t          pend;

  txq_count #(.DEPTH(DEPTH)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_ready (rd_ready),
    .ovf_clr  (ovf_clr),
    .push     (push),
    .pop      (pop),
    .count    (count),
    .is_empty (is_empty),
    .is_full  (is_full),
    .overflow (st_overflow)
  );

  txq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word (wr_word),
    .pop       (pop),
    .head_word (head_word)
  );

  txq_irq #(.DEPTH(DEPTH)) u_irq (
    .count    (count),
    .is_empty (is_empty),
    .is_full  (is_full),
    .lvl_thr  (lvl_thr),
    .irq_en   (irq_en),
    .dma_en   (dma_en),
    .pend     (pend),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  // markers stay stored; raw mode only masks them toward the framer
  assign rd_valid   = !is_empty;
  assign rd_data    = head_word[DATA_W-1:0];
  assign rd_meta    = raw_mode ? '0 : head_word[WORD_W-1:DATA_W];
  assign fill_count = count;
  assign st_empty   = is_empty;
  assign st_full    = is_full;
  assign irq_pend   = pend;

endmodule

// File: rtl/txq_meta_fifo_chk.sv
// Temporal checks on the queue ports, attached by bind.
module txq_meta_fifo_chk #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              ovf_clr,
  input logic              dma_en,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [CW-1:0]     fill_count,
  input logic              st_full,
  input logic              st_overflow,
  input logic [4:0]        irq_pend,
  input logic              dma_req
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH)); // R6

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !st_full && !(rd_valid && rd_ready)) |=> fill_count == $past(fill_count) + 1'b1); // R5

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_valid && rd_ready) |=> fill_count == $past(fill_count) - 1'b1); // R5

  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st_full && !rd_ready) |=> (fill_count == $past(fill_count)) && st_overflow); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overflow && !ovf_clr) |=> st_overflow); // R3

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_en) |=> !rd_valid); // R4

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data)); // R2

  AST_EMPTY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_pend[1:0]) == 1); // R8

  AST_FULL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_pend[3:2]) == 1); // R8

  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req); // R10

endmodule

bind txq_meta_fifo txq_meta_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .ovf_clr     (ovf_clr),
  .dma_en      (dma_en),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .fill_count  (fill_count),
  .st_full     (st_full),
  .st_overflow (st_overflow),
  .irq_pend    (irq_pend),
  .dma_req     (dma_req)
);

// File: tb/txq_meta_fifo_tb_top.sv
module txq_meta_fifo_tb_top;

  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [9:0] wr_word;
  logic       ovf_clr;
  logic       raw_mode;
  logic [4:0] irq_en;
  logic [4:0] lvl_thr;
  logic       dma_en;
  logic       rd_valid;
  logic       rd_ready;
  logic [7:0] rd_data;
  logic [1:0] rd_meta;
  logic [5:0] fill_count;
  logic       st_empty, st_full, st_overflow;
  logic [4:0] irq_pend;
  logic       irq;
  logic       dma_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  logic [9:0] mq[$];
  bit         m_ovf;

  always #10 clk = ~clk;

  txq_meta_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .ovf_clr(ovf_clr),
    .raw_mode(raw_mode), .irq_en(irq_en), .lvl_thr(lvl_thr), .dma_en(dma_en),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_meta(rd_meta),
    .fill_count(fill_count), .st_empty(st_empty), .st_full(st_full),
    .st_overflow(st_overflow), .irq_pend(irq_pend), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [4:0] exp_pend(input int n, input int thr);
    return {n <= thr, n != DEPTH, n == DEPTH, n != 0, n == 0};
  endfunction

  task automatic check_all();
    int n = mq.size();
    logic [4:0] p = exp_pend(n, int'(lvl_thr));
    chk("R5 count", int'(fill_count), n);
    chk("R6 empty", int'(st_empty), int'(n == 0));
    chk("R6 full", int'(st_full), int'(n == DEPTH));
    chk("R4 valid", int'(rd_valid), int'(n != 0));
    chk("R3 overflow", int'(st_overflow), int'(m_ovf));
    chk("R8 pend", int'(irq_pend), int'(p));
    chk("R9 irq", int'(irq), int'(|(p & irq_en)));
    chk("R10 dma", int'(dma_req), int'(dma_en && (n < int'(lvl_thr))));
    if (n != 0) begin
      chk("R2 data", int'(rd_data), int'(mq[0][7:0]));
      chk("R7 meta", int'(rd_meta), raw_mode ? 0 : int'(mq[0][9:8]));
    end
  endtask

  // drive one cycle at the falling edge, predict, then check at the next falling edge
  task automatic cyc(input bit w, input bit r, input bit c, input logic [9:0] d);
    bit acc, pp;
    wr_en = w; rd_ready = r; ovf_clr = c; wr_word = d;
    acc = w && (mq.size() < DEPTH);
    pp  = r && (mq.size() > 0);
    if (c) m_ovf = 1'b0;
    if (w && mq.size() == DEPTH) m_ovf = 1'b1;
    if (pp) void'(mq.pop_front());
    if (acc) mq.push_back(d);
    @(negedge clk);
    check_all();
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd41257));
    rst_n = 1'b0; wr_en = 0; rd_ready = 0; ovf_clr = 0; wr_word = '0;
    raw_mode = 0; irq_en = 5'h1f; lvl_thr = 5'd4; dma_en = 1; m_ovf = 0;
    repeat (3) @(negedge clk);
    // R1: state held during reset
    chk("R1 count", int'(fill_count), 0);
    chk("R1 empty", int'(st_empty), 1);
    chk("R1 full", int'(st_full), 0);
    chk("R1 overflow", int'(st_overflow), 0);
    chk("R1 valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R4/R5: write into empty queue with ready high only adds the word
    cyc(1, 1, 0, 10'h2A5);
    chk("R4 one word", int'(fill_count), 1);
    // R2/R7: fill to full with marked words, then a dropped write
    for (int i = 0; i < 40; i++) cyc(1, 0, 0, 10'((i * 37) ^ (i << 8)));
    chk("R3 held at full", int'(fill_count), DEPTH);
    // R3: write while full with a read in the same cycle is still dropped
    cyc(1, 1, 0, 10'h3FF);
    chk("R3 read+drop", int'(fill_count), DEPTH - 1);
    cyc(1, 0, 0, 10'h155);
    // R3: clear together with a dropped write keeps the flag
    cyc(1, 0, 1, 10'h0AA);
    chk("R3 set beats clear", int'(st_overflow), 1);
    cyc(0, 0, 1, 10'h000);
    chk("R3 cleared", int'(st_overflow), 0);
    // R7: raw mode hides, then restores, stored markers
    raw_mode = 1; cyc(0, 0, 0, 0);
    raw_mode = 0; cyc(0, 0, 0, 0);
    // R4: drain past empty
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 0);
    chk("R4 drained", int'(rd_valid), 0);
    // R8/R10: threshold sweep around the occupancy
    for (int t = 0; t < 6; t++) begin
      lvl_thr = 5'(t);
      cyc(1, 0, 0, 10'(t));
    end

    // constrained random phases: fill-heavy, drain-heavy, balanced
    for (int ph = 0; ph < 30; ph++) begin
      int wp = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 20 : 55;
      int rp = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 85 : 55;
      lvl_thr  = 5'($urandom);
      irq_en   = 5'($urandom);
      dma_en   = pct(70);
      raw_mode = pct(30);
      for (int k = 0; k < 150; k++)
        cyc(pct(wp), pct(rp), pct(5), 10'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule